// File: doc/BRIEF.md
# Data-Strobe Character Decoder

This block turns the bit stream recovered from a data-strobe serial link into link characters. A front end hands it up to `CHUNK` sampled bits per system clock together with a bit-valid strobe and a line-activity flag. The decoder frames these bits into control characters and data characters. It checks the parity of each character against the one before it and validates what follows an escape code. It also watches the activity flag for a silent line. Every result leaves the block as a registered single-cycle strobe: a NULL, a flow-control token, a normal character (flag plus byte), or a time code split into a 2-bit control field and a 6-bit count.

A link controller owns `rx_en`. While `rx_en` is low, every piece of framing, escape and timer state is held cleared. After any error the decoder falls silent until the controller toggles `rx_en`. The controller is expected to restart the link anyway.

Top module: `dsl_rx_decoder`

## Requirements
- R1: While `rst` is high or `rx_en` is low, all strobe outputs are 0 on the following cycle. Any partly received character is discarded, so the next bit after re-enable is taken as a parity bit.
- R2: `bit_in[0]` is the earliest bit of a chunk. Each character is sent as a parity bit, then a flag bit, then its payload least significant bit first. Flag 1 means 2 payload bits (a control code, first bit = code bit 0). Flag 0 means 8 payload bits (a data byte).
- R3: A data character outside an escape raises `nchar_vld` with `nchar_flag`=0 and the byte. Control code 1 (end of packet) gives flag 1 and byte 0x00. Code 2 (error end) gives flag 1 and byte 0x01.
- R4: Control code 0 (flow-control token) not preceded by code 3 (escape) raises `fct_seen`.
- R5: An escape followed by code 0 raises `null_seen`. An escape followed by a data character raises `tcode_vld` with `tcode_ctrl` = byte[7:6] and `tcode_cnt` = byte[5:0]. The escape alone reports nothing.
- R6: An escape followed by code 1, 2 or 3 raises `err_esc`.
- R7: The XOR of the previous character's payload bits, the current parity bit and the current flag bit must be 1. The previous payload counts as 0 for the first character after enable. A failure raises `err_par` in the cycle after the flag bit is taken.
- R8: A character's strobe is high for exactly the one cycle after the clock edge that samples its last bit.
- R9: The silence limit is D = ceil(850 ns × `CLK_HZ`) cycles (85 at 100 MHz). Once `line_act` has been seen high since enable, D consecutive edges with `line_act` low raise `err_disc` for one cycle, right after the D-th such edge. Before the first activity the timer is not armed.
- R10: After any error strobe, no further strobe of any kind appears until `rx_en` goes low.
- R11: At most one of `null_seen`, `fct_seen`, `nchar_vld`, `tcode_vld` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Decoder enable from the link controller |
| line_act | input | 1 | Front end saw a line transition this cycle |
| bit_vld | input | 1 | `bit_in` carries CHUNK new bits |
| bit_in | input | CHUNK | New bits, index 0 earliest |
| null_seen | output | 1 | NULL received |
| fct_seen | output | 1 | Flow-control token received |
| nchar_vld | output | 1 | Normal character received |
| nchar_flag | output | 1 | 1 for an end marker, 0 for data |
| nchar_byte | output | 8 | Data byte, or 0x00/0x01 for end markers |
| tcode_vld | output | 1 | Time code received |
| tcode_ctrl | output | 2 | Time code control field |
| tcode_cnt | output | 6 | Time code counter value |
| err_disc | output | 1 | Line silent for the disconnect limit |
| err_par | output | 1 | Parity failure |
| err_esc | output | 1 | Invalid follower of an escape |

## Verification
Character strobes come one cycle after the edge that samples the last bit of the character. A parity error comes one cycle after the edge that takes the flag bit. The disconnect error follows the D-th silent edge after the last activity. The bench drives inputs on falling edges and reads outputs on falling edges. A per-cycle event log built there keeps the order and count of strobes independent of chunk alignment. The latency and the timeout are checked edge by edge: the strobe must be absent on the falling edge before its due cycle, present on the due one, and gone on the next.

// File: rtl/dsl_rx_pkg.sv
package dsl_rx_pkg;

   typedef enum logic [1:0] {
      CC_FCT = 2'd0,
      CC_EOP = 2'd1,
      CC_EEP = 2'd2,
      CC_ESC = 2'd3
   } ctl_code_e;

   localparam int unsigned CTRL_LEN = 4;
   localparam int unsigned DATA_LEN = 10;

   typedef struct packed {
      logic       done;
      logic       is_ctl;
      logic [7:0] payload;
      logic       par_err;
   } asm_res_t;

endpackage

// File: rtl/dsl_rx_assembler.sv
module dsl_rx_assembler
   import dsl_rx_pkg::*;
#(
   parameter int unsigned CHUNK = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             stop,
   input  logic             bit_vld,
   input  logic [CHUNK-1:0] bit_in,
   output asm_res_t         res
);

   localparam int unsigned POS_W = $clog2(DATA_LEN);

   logic [POS_W-1:0] pos_q, pos_v;
   logic             ctl_q, ctl_v;
   logic             pacc_q, pacc_v;
   logic [7:0]       sh_q, sh_v;

   always_comb begin
      logic b;
      pos_v  = pos_q;
      ctl_v  = ctl_q;
      pacc_v = pacc_q;
      sh_v   = sh_q;
      res    = '0;
      b      = 1'b0;
      for (int i = 0; i < CHUNK; i++) begin
         if (bit_vld && !stop && !res.par_err) begin
            b = bit_in[i];
            if (pos_v == '0) begin
               pacc_v = pacc_v ^ b;
               pos_v  = POS_W'(1);
            end else if (pos_v == POS_W'(1)) begin
               if (!(pacc_v ^ b)) res.par_err = 1'b1;
               ctl_v  = b;
               pacc_v = 1'b0;
               pos_v  = POS_W'(2);
            end else begin
               pacc_v = pacc_v ^ b;
               sh_v   = {b, sh_v[7:1]};
               if (pos_v == (ctl_v ? POS_W'(CTRL_LEN-1) : POS_W'(DATA_LEN-1))) begin
                  res.done    = 1'b1;
                  res.is_ctl  = ctl_v;
                  res.payload = sh_v;
                  pos_v       = '0;
               end else begin
                  pos_v = pos_v + POS_W'(1);
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         pos_q  <= '0;
         ctl_q  <= 1'b0;
         pacc_q <= 1'b0;
         sh_q   <= '0;
      end else begin
         pos_q  <= pos_v;
         ctl_q  <= ctl_v;
         pacc_q <= pacc_v;
         sh_q   <= sh_v;
      end
   end

endmodule

// File: rtl/dsl_rx_classifier.sv
module dsl_rx_classifier
   import dsl_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  logic       stop,
   input  asm_res_t   res,
   output logic       null_seen,
   output logic       fct_seen,
   output logic       nchar_vld,
   output logic       nchar_flag,
   output logic [7:0] nchar_byte,
   output logic       tcode_vld,
   output logic [1:0] tcode_ctrl,
   output logic [5:0] tcode_cnt,
   output logic       err_par,
   output logic       err_esc
);

   logic esc_q;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         esc_q      <= 1'b0;
         null_seen  <= 1'b0;
         fct_seen   <= 1'b0;
         nchar_vld  <= 1'b0;
         nchar_flag <= 1'b0;
         nchar_byte <= '0;
         tcode_vld  <= 1'b0;
         tcode_ctrl <= '0;
         tcode_cnt  <= '0;
         err_par    <= 1'b0;
         err_esc    <= 1'b0;
      end else begin
         null_seen <= 1'b0;
         fct_seen  <= 1'b0;
         nchar_vld <= 1'b0;
         tcode_vld <= 1'b0;
         err_par   <= 1'b0;
         err_esc   <= 1'b0;
         if (!stop) begin
            err_par <= res.par_err;
            if (res.done && res.is_ctl) begin
               if (esc_q) begin
                  esc_q <= 1'b0;
                  if (ctl_code_e'(res.payload[7:6]) == CC_FCT) null_seen <= 1'b1;
                  else                                          err_esc   <= 1'b1;
               end else begin
                  case (ctl_code_e'(res.payload[7:6]))
                     CC_FCT: fct_seen <= 1'b1;
                     CC_EOP: begin
                        nchar_vld  <= 1'b1;
                        nchar_flag <= 1'b1;
                        nchar_byte <= 8'h00;
                     end
                     CC_EEP: begin
                        nchar_vld  <= 1'b1;
                        nchar_flag <= 1'b1;
                        nchar_byte <= 8'h01;
                     end
                     default: esc_q <= 1'b1;
                  endcase
               end
            end else if (res.done) begin
               if (esc_q) begin
                  esc_q      <= 1'b0;
                  tcode_vld  <= 1'b1;
                  tcode_ctrl <= res.payload[7:6];
                  tcode_cnt  <= res.payload[5:0];
               end else begin
                  nchar_vld  <= 1'b1;
                  nchar_flag <= 1'b0;
                  nchar_byte <= res.payload;
               end
            end
         end
      end
   end

endmodule

// File: rtl/dsl_rx_disc_timer.sv
module dsl_rx_disc_timer #(
   parameter int unsigned LIMIT = 85
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic stop,
   input  logic line_act,
   output logic err_disc
);

   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic          armed_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         armed_q  <= 1'b0;
         cnt_q    <= '0;
         err_disc <= 1'b0;
      end else if (line_act) begin
         armed_q  <= 1'b1;
         cnt_q    <= '0;
         err_disc <= 1'b0;
      end else begin
         err_disc <= 1'b0;
         if (armed_q && !stop) begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(LIMIT - 1)) begin
               err_disc <= 1'b1;
               armed_q  <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/dsl_rx_decoder.sv
module dsl_rx_decoder
   import dsl_rx_pkg::*;
#(
   parameter int unsigned CLK_HZ = 100_000_000,
   parameter int unsigned CHUNK  = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_en,
   input  logic             line_act,
   input  logic             bit_vld,
   input  logic [CHUNK-1:0] bit_in,
   output logic             null_seen,
   output logic             fct_seen,
   output logic             nchar_vld,
   output logic             nchar_flag,
   output logic [7:0]       nchar_byte,
   output logic             tcode_vld,
   output logic [1:0]       tcode_ctrl,
   output logic [5:0]       tcode_cnt,
   output logic             err_disc,
   output logic             err_par,
   output logic             err_esc
);

   localparam int unsigned DISC_CYC =
      int'((64'(CLK_HZ) * 64'd85 + 64'd99_999_999) / 64'd100_000_000);

   if (CHUNK < 1 || CHUNK > 4) begin : g_bad_chunk
      $error("dsl_rx_decoder: CHUNK must lie in 1..4");
   end
   if (DISC_CYC < 2) begin : g_bad_clk
      $error("dsl_rx_decoder: CLK_HZ too low for the silence limit");
   end

   asm_res_t res;
   logic     halted_q;
   logic     stop;

   assign stop = halted_q | err_par | err_esc | err_disc;

   always_ff @(posedge clk) begin
      if (rst || !rx_en) halted_q <= 1'b0;
      else if (stop)     halted_q <= 1'b1;
   end

   dsl_rx_assembler #(.CHUNK(CHUNK)) u_asm (
      .clk     (clk),
      .rst     (rst),
      .en      (rx_en),
      .stop    (stop),
      .bit_vld (bit_vld),
      .bit_in  (bit_in),
      .res     (res)
   );

   dsl_rx_classifier u_cls (
      .clk        (clk),
      .rst        (rst),
      .en         (rx_en),
      .stop       (stop),
      .res        (res),
      .null_seen  (null_seen),
      .fct_seen   (fct_seen),
      .nchar_vld  (nchar_vld),
      .nchar_flag (nchar_flag),
      .nchar_byte (nchar_byte),
      .tcode_vld  (tcode_vld),
      .tcode_ctrl (tcode_ctrl),
      .tcode_cnt  (tcode_cnt),
      .err_par    (err_par),
      .err_esc    (err_esc)
   );

   dsl_rx_disc_timer #(.LIMIT(DISC_CYC)) u_disc (
      .clk      (clk),
      .rst      (rst),
      .en       (rx_en),
      .stop     (stop),
      .line_act (line_act),
      .err_disc (err_disc)
   );

endmodule

// File: rtl/dsl_rx_decoder_chk.sv
module dsl_rx_decoder_chk #(
   parameter int unsigned CHUNK = 1
) (
   input logic             clk,
   input logic             rst,
   input logic             rx_en,
   input logic             line_act,
   input logic             bit_vld,
   input logic [CHUNK-1:0] bit_in,
   input logic             null_seen,
   input logic             fct_seen,
   input logic             nchar_vld,
   input logic             nchar_flag,
   input logic [7:0]       nchar_byte,
   input logic             tcode_vld,
   input logic [1:0]       tcode_ctrl,
   input logic [5:0]       tcode_cnt,
   input logic             err_disc,
   input logic             err_par,
   input logic             err_esc
);

   logic any_out, any_err;
   assign any_err = err_par | err_esc | err_disc;
   assign any_out = null_seen | fct_seen | nchar_vld | tcode_vld | any_err;

   a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
      !rx_en |=> !any_out);

   a_r11_one_char: assert property (@(posedge clk) disable iff (rst)
      $onehot0({null_seen, fct_seen, nchar_vld, tcode_vld}));

   a_r3_marker_byte: assert property (@(posedge clk) disable iff (rst)
      (nchar_vld && nchar_flag) |-> (nchar_byte[7:1] == 7'd0));

   a_r9_disc_needs_silence: assert property (@(posedge clk) disable iff (rst)
      err_disc |-> !$past(line_act));

   a_r10_silent_after_err: assert property (@(posedge clk) disable iff (rst)
      any_err |=> !any_out);

endmodule

bind dsl_rx_decoder dsl_rx_decoder_chk #(.CHUNK(CHUNK)) u_chk (.*);

// File: tb/tb_dsl_rx_decoder.sv
module tb_dsl_rx_decoder;

   localparam int CHUNK  = 2;
   localparam int CLK_HZ = 100_000_000;
   localparam int DISC   = 85;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             rx_en = 1'b0;
   logic             line_act = 1'b0;
   logic             bit_vld = 1'b0;
   logic [CHUNK-1:0] bit_in = '0;
   logic             null_seen, fct_seen, nchar_vld, nchar_flag, tcode_vld;
   logic [7:0]       nchar_byte;
   logic [1:0]       tcode_ctrl;
   logic [5:0]       tcode_cnt;
   logic             err_disc, err_par, err_esc;

   dsl_rx_decoder #(.CLK_HZ(CLK_HZ), .CHUNK(CHUNK)) dut (
      .clk(clk), .rst(rst), .rx_en(rx_en), .line_act(line_act),
      .bit_vld(bit_vld), .bit_in(bit_in),
      .null_seen(null_seen), .fct_seen(fct_seen),
      .nchar_vld(nchar_vld), .nchar_flag(nchar_flag), .nchar_byte(nchar_byte),
      .tcode_vld(tcode_vld), .tcode_ctrl(tcode_ctrl), .tcode_cnt(tcode_cnt),
      .err_disc(err_disc), .err_par(err_par), .err_esc(err_esc)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
      end
   endtask

   // event codes: 1 null, 2 fct, 3 nchar {flag,byte}, 4 tcode {0,ctrl,cnt}, 5 par, 6 esc, 7 disc
   logic [11:0] ev_log [0:63];
   int          ev_n = 0;
   bit          log_on = 0;

   task automatic log_ev(input logic [11:0] e);
      if (ev_n < 64) ev_log[ev_n] = e;
      ev_n++;
   endtask

   always @(negedge clk) begin
      if (log_on) begin
         if (err_par)   log_ev({3'd5, 9'd0});
         if (err_esc)   log_ev({3'd6, 9'd0});
         if (err_disc)  log_ev({3'd7, 9'd0});
         if (null_seen) log_ev({3'd1, 9'd0});
         if (fct_seen)  log_ev({3'd2, 9'd0});
         if (nchar_vld) log_ev({3'd3, nchar_flag, nchar_byte});
         if (tcode_vld) log_ev({3'd4, 1'b0, tcode_ctrl, tcode_cnt});
      end
   end

   bit sq[$];
   bit tb_prev = 0;

   task automatic put_char(input bit ctl, input logic [7:0] pl, input bit bad);
      int n = ctl ? 2 : 8;
      bit acc = 0;
      for (int k = 0; k < n; k++) acc ^= pl[k];
      sq.push_back(1'b1 ^ tb_prev ^ ctl ^ bad);
      sq.push_back(ctl);
      for (int k = 0; k < n; k++) sq.push_back(pl[k]);
      tb_prev = acc;
   endtask

   task automatic flush();
      while (sq.size() >= CHUNK) begin
         @(negedge clk);
         bit_vld  = 1'b1;
         line_act = 1'b1;
         for (int j = 0; j < CHUNK; j++) bit_in[j] = sq.pop_front();
         @(posedge clk);
      end
      @(negedge clk);
      bit_vld  = 1'b0;
      line_act = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic restart();
      @(negedge clk);
      rx_en    = 1'b0;
      bit_vld  = 1'b0;
      line_act = 1'b0;
      sq.delete();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rx_en   = 1'b1;
      tb_prev = 0;
      ev_n    = 0;
      log_on  = 1;
   endtask

   task automatic check_ev(input int idx, input logic [11:0] e, input string req);
      chk(ev_n > idx && ev_log[idx] == e, req, (ev_n > idx) ? int'(ev_log[idx]) : -1, int'(e));
   endtask

   // {kind[1:0], payload[7:0], exp_type[2:0], exp_data[8:0]}
   // kind 0: control code, 1: data, 2: escape+token, 3: escape+data
   localparam logic [21:0] VEC [0:8] = '{
      {2'd0, 8'h00, 3'd2, 9'h000},
      {2'd1, 8'hA5, 3'd3, 9'h0A5},
      {2'd0, 8'h01, 3'd3, 9'h100},
      {2'd0, 8'h02, 3'd3, 9'h101},
      {2'd2, 8'h00, 3'd1, 9'h000},
      {2'd3, 8'h9C, 3'd4, 9'h09C},
      {2'd1, 8'h00, 3'd3, 9'h000},
      {2'd1, 8'hFF, 3'd3, 9'h0FF},
      {2'd3, 8'h41, 3'd4, 9'h041}
   };

   initial begin
      #(200_000 * 10);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int first, hits;
      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({null_seen, fct_seen, nchar_vld, tcode_vld, err_disc, err_par, err_esc} == '0,
          "R1 reset", {null_seen, fct_seen, nchar_vld, tcode_vld, err_disc, err_par, err_esc}, 0);
      rst = 1'b0;

      // R2 R3 R4 R5 table of characters
      restart();
      for (int i = 0; i < 9; i++) begin
         logic [21:0] v = VEC[i];
         case (v[21:20])
            2'd0: put_char(1, v[19:12], 0);
            2'd1: put_char(0, v[19:12], 0);
            2'd2: begin put_char(1, 8'h03, 0); put_char(1, 8'h00, 0); end
            default: begin put_char(1, 8'h03, 0); put_char(0, v[19:12], 0); end
         endcase
      end
      flush();
      chk(ev_n == 9, "R2 event count", ev_n, 9);
      for (int i = 0; i < 9; i++) begin
         logic [21:0] v = VEC[i];
         check_ev(i, v[11:0], "R3 R4 R5 table entry");
      end

      // R8 latency of a token
      restart();
      put_char(1, 8'h00, 0);
      @(negedge clk);
      bit_vld = 1; line_act = 1;
      for (int j = 0; j < CHUNK; j++) bit_in[j] = sq.pop_front();
      @(posedge clk);
      @(negedge clk);
      chk(fct_seen == 0, "R8 early", fct_seen, 0);
      for (int j = 0; j < CHUNK; j++) bit_in[j] = sq.pop_front();
      @(posedge clk);
      @(negedge clk);
      chk(fct_seen == 1, "R8 due", fct_seen, 1);
      bit_vld = 0; line_act = 0;
      @(negedge clk);
      chk(fct_seen == 0, "R8 one cycle", fct_seen, 0);

      // R1 partial character discarded on disable
      restart();
      sq.push_back(1'b1); sq.push_back(1'b0);
      flush();
      restart();
      put_char(1, 8'h00, 0);
      flush();
      chk(ev_n == 1, "R1 cleared count", ev_n, 1);
      check_ev(0, {3'd2, 9'd0}, "R1 cleared framing");

      // R7 R10 parity failure
      restart();
      put_char(1, 8'h00, 0);
      put_char(1, 8'h00, 1);
      put_char(1, 8'h00, 0);
      flush();
      chk(ev_n == 2, "R7 R10 count", ev_n, 2);
      check_ev(0, {3'd2, 9'd0}, "R7 first token");
      check_ev(1, {3'd5, 9'd0}, "R7 parity error");

      // R6 R10 escape then end marker
      restart();
      put_char(1, 8'h00, 0);
      put_char(1, 8'h03, 0);
      put_char(1, 8'h01, 0);
      put_char(1, 8'h00, 0);
      flush();
      chk(ev_n == 2, "R6 R10 count", ev_n, 2);
      check_ev(1, {3'd6, 9'd0}, "R6 escape then marker");

      // R6 escape then escape
      restart();
      put_char(1, 8'h03, 0);
      put_char(1, 8'h03, 0);
      flush();
      chk(ev_n == 1, "R6 double escape count", ev_n, 1);
      check_ev(0, {3'd6, 9'd0}, "R6 double escape");

      // R9 timer not armed before activity
      restart();
      repeat (150) @(negedge clk);
      chk(ev_n == 0, "R9 unarmed", ev_n, 0);
      // R9 timeout position
      line_act = 1;
      @(posedge clk);
      @(negedge clk);
      line_act = 0;
      first = -1; hits = 0;
      for (int j = 1; j <= DISC + 20; j++) begin
         @(negedge clk);
         if (err_disc) begin
            hits++;
            if (first < 0) first = j;
         end
      end
      chk(first == DISC, "R9 timeout cycle", first, DISC);
      chk(hits == 1, "R9 single pulse", hits, 1);
      // R10 silent after disconnect
      put_char(1, 8'h00, 0);
      flush();
      chk(ev_n == 1, "R10 after disconnect", ev_n, 1);
      check_ev(0, {3'd7, 9'd0}, "R9 logged");

      // R10 recovers after re-enable
      restart();
      put_char(0, 8'h3C, 0);
      flush();
      check_ev(0, {3'd3, 9'h03C}, "R10 recovery");

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule